// File: doc/BRIEF.md
# MII to 4B/5B Transmit Adapter

The adapter takes Ethernet packet nibbles from a MAC and turns them into a stream of 5-bit 4B/5B code groups for a link framer. The MAC raises its enable to start a packet. The adapter then emits the two start delimiters (J, then K). After that it asks for each nibble with a one-cycle ready pulse. It samples enable, data and error in the cycle after each pulse and replaces the line group with the code of that nibble. When the sampled enable is low, the packet ends with the T and R delimiters, and the line returns to IDLE.

The framer throttles the adapter with a busy input. While busy is high, ready stays low. The MAC must hold its nibble until the sample cycle that follows the next ready pulse. Between those sample points the enable, data and error inputs are not examined. This means a short dip in enable during a stall does not end the packet. Only a low enable in a sample cycle closes the packet. The line output is a level: each code group stays on the output until the next group replaces it.

Top module: `mii4b5b_tx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `line_grp` is IDLE (11111) and `mac_rdy` is low.
- R2: A high `mac_en` seen at a clock edge while the line is IDLE puts J (11000) on `line_grp` for the next cycle, then K (10001) for the cycle after that, and K again in the following cycle. The values of `mac_en`, `mac_nib` and `mac_err` during the J and K cycles do not change this sequence.
- R3: `mac_rdy` is never high in two consecutive cycles. In the data phase, with `lnk_busy` low, it rises again in the cycle after each sample cycle. Its first rise comes in the cycle after the first K cycle.
- R4: A high `lnk_busy` in a cycle forces `mac_rdy` low in the next cycle.
- R5: The sample cycle is the cycle after a `mac_rdy` cycle. At the end of the sample cycle, if `mac_en` is high and `mac_err` is low, `line_grp` takes the code of `mac_nib` for the next cycle. The codes are: 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R6: In the data phase, `mac_en`, `mac_nib` and `mac_err` have no effect in any cycle other than a sample cycle. A low enable during a stall is not seen if enable is high again in the sample cycle.
- R7: A sample cycle with `mac_en` and `mac_err` both high puts H (00100) on `line_grp` in place of the nibble code.
- R8: A sample cycle with `mac_en` low puts T (01101) on `line_grp` for the next cycle, then R (00111), then IDLE. `mac_rdy` stays low in all three of those cycles.
- R9: `line_grp` in the cycle after a `mac_rdy` cycle equals its value in the `mac_rdy` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mac_en | input | 1 | Packet enable from the MAC |
| mac_nib | input | 4 | Data nibble from the MAC |
| mac_err | input | 1 | Error flag for the current nibble |
| lnk_busy | input | 1 | Framer cannot take a new group soon; stalls ready |
| mac_rdy | output | 1 | Nibble request pulse to the MAC |
| line_grp | output | 5 | Current 4B/5B code group on the line |

## Verification
The nibble values in the packets cover all sixteen codes, and some packets are empty or hold a single nibble. This shows that the code table and both delimiter pairs are correct, independent of packet length. Four busy patterns are used: never busy, busy every third cycle, and two patterns with long bursts. Together they show that sampling follows the ready pulse rather than a fixed cadence. In half of the packets the MAC drives a low enable, flipped data and a high error in every cycle where nothing is sampled, including the J and K cycles. A block that looked at its inputs outside the sample cycle would then close the packet early or emit H. Error markers placed at different positions show that H replaces exactly one group.

// File: rtl/mii4b5b_pkg.sv
package mii4b5b_pkg;
  localparam int NIB_W = 4;
  localparam int GRP_W = 5;

  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [GRP_W-1:0] grp_t;

  localparam grp_t G_IDLE = 5'b11111;
  localparam grp_t G_J    = 5'b11000;
  localparam grp_t G_K    = 5'b10001;
  localparam grp_t G_T    = 5'b01101;
  localparam grp_t G_R    = 5'b00111;
  localparam grp_t G_H    = 5'b00100;

  // what the line currently carries
  typedef enum logic [2:0] {
    LN_IDLE, LN_J, LN_K, LN_DATA, LN_T, LN_R
  } line_st_e;

  function automatic grp_t enc_nib(nib_t n);
    grp_t g;
    case (n)
      4'h0: g = 5'b11110;
      4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;
      4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;
      4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;
      4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;
      4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;
      4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;
      4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;
      default: g = 5'b11101;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/mii4b5b_enc.sv
module mii4b5b_enc
  import mii4b5b_pkg::*;
(
  input  nib_t nib_i,
  input  logic err_i,
  output grp_t grp_o
);
  assign grp_o = err_i ? G_H : enc_nib(nib_i);
endmodule

// File: rtl/mii4b5b_pacer.sv
module mii4b5b_pacer (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic busy_i,
  output logic rdy_o,
  output logic samp_o
);
  logic rdy_q, samp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      samp_q <= 1'b0;
    end else begin
      rdy_q  <= run_i && !rdy_q && !busy_i;
      samp_q <= rdy_q;
    end
  end

  assign rdy_o  = rdy_q;
  assign samp_o = samp_q;
endmodule

// File: rtl/mii4b5b_fsm.sv
module mii4b5b_fsm
  import mii4b5b_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic samp_i,
  input  grp_t grp_i,
  output logic run_o,
  output logic accept_o,
  output logic close_o,
  output grp_t code_o
);
  line_st_e st_q, st_n;
  grp_t     code_q, code_n;

  assign accept_o = (st_q == LN_DATA) && samp_i && en_i;
  assign close_o  = (st_q == LN_DATA) && samp_i && !en_i;

  always_comb begin
    st_n   = st_q;
    code_n = code_q;
    case (st_q)
      LN_IDLE: if (en_i) begin st_n = LN_J; code_n = G_J; end
      LN_J:    begin st_n = LN_K; code_n = G_K; end
      LN_K:    st_n = LN_DATA;
      LN_DATA: begin
        if (accept_o) code_n = grp_i;
        else if (close_o) begin st_n = LN_T; code_n = G_T; end
      end
      LN_T:    begin st_n = LN_R; code_n = G_R; end
      LN_R:    begin st_n = LN_IDLE; code_n = G_IDLE; end
      default: begin st_n = LN_IDLE; code_n = G_IDLE; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LN_IDLE;
      code_q <= G_IDLE;
    end else begin
      st_q   <= st_n;
      code_q <= code_n;
    end
  end

  assign run_o  = (st_n == LN_DATA);
  assign code_o = code_q;
endmodule

// File: rtl/mii4b5b_tx.sv
module mii4b5b_tx
  import mii4b5b_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mac_en,
  input  logic [NIB_W-1:0] mac_nib,
  input  logic             mac_err,
  input  logic             lnk_busy,
  output logic             mac_rdy,
  output logic [GRP_W-1:0] line_grp
);
  logic run_w, samp_w, accept_w, close_w;
  grp_t enc_w;

  mii4b5b_enc enc_i (
    .nib_i (mac_nib),
    .err_i (mac_err),
    .grp_o (enc_w)
  );

  mii4b5b_pacer pacer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_w),
    .busy_i (lnk_busy),
    .rdy_o  (mac_rdy),
    .samp_o (samp_w)
  );

  mii4b5b_fsm fsm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (mac_en),
    .samp_i   (samp_w),
    .grp_i    (enc_w),
    .run_o    (run_w),
    .accept_o (accept_w),
    .close_o  (close_w),
    .code_o   (line_grp)
  );
endmodule

// File: rtl/mii4b5b_chk.sv
module mii4b5b_chk
  import mii4b5b_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic mac_err,
  input logic lnk_busy,
  input logic mac_rdy,
  input grp_t line_grp,
  input logic accept,
  input logic close
);
  // R3
  rdy_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mac_rdy |=> !mac_rdy);
  // R4
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_busy |=> !mac_rdy);
  // R2
  j_then_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_grp == G_J) |=> (line_grp == G_K));
  // R8
  t_then_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_grp == G_T) |=> (line_grp == G_R));
  // R8
  r_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_grp == G_R) |=> (line_grp == G_IDLE));
  // R8
  close_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> (line_grp == G_T));
  // R5
  accept_after_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept || close) |-> $past(mac_rdy));
  // R7
  err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mac_err) |=> (line_grp == G_H));
  // R9
  hold_after_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mac_rdy |=> $stable(line_grp));
endmodule

bind mii4b5b_tx mii4b5b_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .mac_err  (mac_err),
  .lnk_busy (lnk_busy),
  .mac_rdy  (mac_rdy),
  .line_grp (line_grp),
  .accept   (accept_w),
  .close    (close_w)
);

// File: tb/mii4b5b_tx_tb_top.sv
`timescale 1ns/1ps
module mii4b5b_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mac_en = 1'b0;
  logic [3:0] mac_nib = 4'h0;
  logic       mac_err = 1'b0;
  logic       lnk_busy = 1'b0;
  logic       mac_rdy;
  logic [4:0] line_grp;

  localparam logic [4:0] E_IDLE = 5'b11111, E_J = 5'b11000, E_K = 5'b10001,
                         E_T = 5'b01101, E_R = 5'b00111, E_H = 5'b00100;
  localparam logic [4:0] CODES [16] = '{5'h1E, 5'h09, 5'h14, 5'h15, 5'h0A, 5'h0B,
                                        5'h0E, 5'h0F, 5'h12, 5'h13, 5'h16, 5'h17,
                                        5'h1A, 5'h1B, 5'h1C, 5'h1D};

  int checks = 0, errors = 0, cyc = 0;
  bit last_rdy = 0, was_rdy = 0;
  bit         sl_v [5];
  logic [4:0] sl_c [5];
  string      sl_t [5];
  bit         sl_z [5];

  always #4 clk = ~clk;

  mii4b5b_tx dut_i (
    .clk(clk), .rst_n(rst_n), .mac_en(mac_en), .mac_nib(mac_nib),
    .mac_err(mac_err), .lnk_busy(lnk_busy), .mac_rdy(mac_rdy), .line_grp(line_grp)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  function automatic int busy_fn(int mode, int c);
    case (mode)
      1: return (c % 3 == 0) ? 1 : 0;
      2: return (c % 7 < 4) ? 1 : 0;
      3: return (c % 11 < 8) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic sched(int d, logic [4:0] c, string tag, bit z);
    sl_v[d-1] = 1; sl_c[d-1] = c; sl_t[d-1] = tag; sl_z[d-1] = z;
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (lnk_busy) chk(!mac_rdy, "R4 busy stall", mac_rdy, 0);
    if (last_rdy) chk(!mac_rdy, "R3 ready spacing", mac_rdy, 0);
    if (sl_v[0]) chk(line_grp == sl_c[0], sl_t[0], line_grp, sl_c[0]);
    if (sl_z[0]) chk(!mac_rdy, "R8 ready quiet", mac_rdy, 0);
    for (int i = 0; i < 4; i++) begin
      sl_v[i] = sl_v[i+1]; sl_c[i] = sl_c[i+1]; sl_t[i] = sl_t[i+1]; sl_z[i] = sl_z[i+1];
    end
    sl_v[4] = 0; sl_z[4] = 0;
    was_rdy = last_rdy;
    last_rdy = mac_rdy;
  endtask

  task automatic send_packet(int len, int base, int mode, bit glitch, int erpos);
    int n = 0;
    bit done = 0;
    logic [3:0] nib;
    tick();
    mac_en = 1; mac_nib = 4'(base); mac_err = 0;
    lnk_busy = busy_fn(mode, cyc) != 0;
    sched(1, E_J, "R2 J group", 1);
    sched(2, E_K, "R2 K group", 1);
    sched(3, E_K, "R2 K hold", 0);
    while (!done) begin
      tick();
      lnk_busy = busy_fn(mode, cyc) != 0;
      if (mac_rdy) begin
        sched(1, line_grp, "R9 hold", 0);
        if (n < len) begin
          nib = 4'((n + base) % 16);
          mac_en = 1; mac_nib = nib; mac_err = (n == erpos);
          if (n == erpos) sched(2, E_H, "R7 halt", 0);
          else sched(2, CODES[nib], glitch ? "R6 nibble" : "R5 nibble", 0);
          n++;
        end else begin
          mac_en = 0; mac_err = 0;
          sched(2, E_T, "R8 T group", 1);
          sched(3, E_R, "R8 R group", 1);
          sched(4, E_IDLE, "R8 idle", 1);
          done = 1;
        end
      end else if (glitch && !was_rdy) begin
        // R6: noise outside sample cycles (also covers J/K cycles for R2)
        mac_en = 0; mac_nib = ~mac_nib; mac_err = 1;
      end
    end
    mac_err = 0; lnk_busy = 0;
    repeat (5) tick();
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin sl_v[i] = 0; sl_z[i] = 0; sl_c[i] = 0; sl_t[i] = ""; end
    repeat (3) @(negedge clk);
    chk(line_grp == E_IDLE, "R1 reset group", line_grp, E_IDLE);
    chk(!mac_rdy, "R1 reset ready", mac_rdy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(line_grp == E_IDLE, "R1 idle after reset", line_grp, E_IDLE);
    chk(!mac_rdy, "R1 ready after reset", mac_rdy, 0);
    send_packet(0, 0, 0, 0, -1);
    send_packet(1, 9, 1, 1, -1);
    for (int m = 0; m < 4; m++)
      for (int g = 0; g < 2; g++)
        send_packet(16, m * 3 + g, m, g[0], g ? 3 + m : -1);
    send_packet(16, 5, 0, 0, 15);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule